// File: doc/BRIEF.md
# Split-Access 64-bit Register Bridge

This block connects a 32-bit bus master to a bank of 64-bit registers. Each 64-bit register occupies two neighbouring word addresses: the even word address carries bits 63:32 and the odd word address carries bits 31:0. Writing the even word only parks the upper half in a staging register. Writing the odd word then updates all 64 bits at once, taking the staged upper half and the new lower half together.

Reads go the other way. The first read of either half returns the live half and freezes the other half in a shadow latch. The next read of that other half of the same register returns the frozen value, so two 32-bit reads form one snapshot even while the register moves. The bank holds a parameterised number of configuration registers, followed by free-running 64-bit event counters. Configuration register 0 carries a self-clearing soft-reset command bit. That command clears the counters and raises a one-cycle pulse for the rest of the chip.

The bus is a single request port: valid, write, word address and data. Read data returns one cycle after the request.

Top module: `split64_bridge`

## Requirements
- R1: After reset every configuration register and every event counter reads as zero, `bus_rvalid` is low and `soft_rst_o` is low.
- R2: A write to the even word of a configuration register (word address bit 0 = 0) changes no register. It only stages the upper half, so reading that register back still shows its old value.
- R3: A write to the odd word of a configuration register loads the register with {staged upper half, written word} at that clock edge. The staging register then returns to zero, so an odd-word write with no even-word write before it commits zero in bits 63:32.
- R4: A read of one half that is not waiting on a capture returns the live half. It also captures the other half of the same register. A following read of that other half of the same register returns the captured value, even if the register has changed in between.
- R5: A captured half is returned only once. Any other mapped read refreshes the capture and starts a new pair: a read of a different register, or a repeat read of the same half.
- R6: Each event counter adds one at every clock edge at which its strobe bit `event_i[k]` is high. This also holds while a split read of that counter is under way. Counter k sits at register index NUM_CFG+k.
- R7: A commit to register 0 with bit 31 of the written odd word set acts as a soft-reset command. It clears all event counters at that edge and drives `soft_rst_o` high for exactly the next cycle. Bit 31 of register 0 is stored as zero.
- R8: Register indices at or above NUM_CFG+NUM_CNT read as zero. Reads of these indices leave a pending capture in place. Writes to them, and writes to counter registers, change nothing.
- R9: `bus_rvalid` is high in exactly the cycle after a read request, and `bus_rdata` carries that read's data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address; bit 0 selects the half, upper bits the register |
| bus_wdata | input | DATA_W | Write data |
| event_i | input | NUM_CNT | Counter increment strobes |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| soft_rst_o | output | 1 | One-cycle pulse after a soft-reset commit |

## Verification
The bench builds the block with DATA_W=32, NUM_CFG=2, NUM_CNT=3 and ADDR_W=5. That gives two configuration registers, so a shadow refresh across registers can be exercised, and three counters, so captures can be taken under changing strobes. Eleven of the sixteen register indices are unmapped, so random addresses often fall outside the map. A 32-bit data width keeps the soft-reset bit at the top of the odd word, and random write data sets it often enough to mix counter clears into the random traffic.

// File: rtl/split64_pkg.sv
package split64_pkg;
   // which half of a 64-bit register a word address selects
   typedef enum logic {
      HALF_UPPER = 1'b0,   // even word address, bits 63:32
      HALF_LOWER = 1'b1    // odd word address, bits 31:0
   } half_e;
endpackage

// File: rtl/split64_cfg_bank.sv
module split64_cfg_bank
   import split64_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_CFG  = 2,
   parameter int IDX_W    = 4,
   parameter int SRST_BIT = 31,
   localparam int REG_W   = 2 * DATA_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  half_e                           wr_half,
   input  logic [DATA_W-1:0]               wdata,
   output logic [NUM_CFG-1:0][REG_W-1:0]   cfg_q,
   output logic                            srst_cmd
);
   localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << SRST_BIT;

   logic [DATA_W-1:0] stage_q;
   logic              commit;

   assign commit   = wr_en && (wr_half == HALF_LOWER);
   assign srst_cmd = commit && (wr_idx == '0) && wdata[SRST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (wr_en) begin
         if (wr_half == HALF_UPPER) stage_q <= wdata;
         else                       stage_q <= '0;
      end
   end

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
      localparam logic [DATA_W-1:0] KEEP = (g == 0) ? ~SRST_MASK : '1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[g] <= '0;
         end else if (commit && (wr_idx == IDX_W'(g))) begin
            cfg_q[g] <= {stage_q, wdata & KEEP};
         end
      end
   end
endmodule

// File: rtl/split64_event_ctr.sv
module split64_event_ctr #(
   parameter int REG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ev,
   output logic [REG_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (ev)  count <= count + REG_W'(1);
   end
endmodule

// File: rtl/split64_read_port.sv
module split64_read_port
   import split64_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   localparam int REG_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              mapped,
   input  logic [IDX_W-1:0]  idx,
   input  half_e             half,
   input  logic [REG_W-1:0]  live,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   logic [DATA_W-1:0] shadow_q;
   logic              pend_q;
   logic [IDX_W-1:0]  pidx_q;
   half_e             phalf_q;
   logic              hit;
   logic [DATA_W-1:0] live_hi, live_lo;

   assign live_hi = live[REG_W-1:DATA_W];
   assign live_lo = live[DATA_W-1:0];
   assign hit     = pend_q && (pidx_q == idx) && (phalf_q == half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rvalid   <= 1'b0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
         pidx_q   <= '0;
         phalf_q  <= HALF_UPPER;
      end else begin
         rvalid <= rd_en;
         if (rd_en) begin
            if (!mapped) begin
               rdata <= '0;
            end else if (hit) begin
               rdata  <= shadow_q;
               pend_q <= 1'b0;
            end else begin
               pend_q <= 1'b1;
               pidx_q <= idx;
               if (half == HALF_LOWER) begin
                  rdata    <= live_lo;
                  shadow_q <= live_hi;
                  phalf_q  <= HALF_UPPER;
               end else begin
                  rdata    <= live_hi;
                  shadow_q <= live_lo;
                  phalf_q  <= HALF_LOWER;
               end
            end
         end
      end
   end
endmodule

// File: rtl/split64_bridge.sv
module split64_bridge
   import split64_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_CFG  = 2,
   parameter int NUM_CNT  = 3,
   parameter int ADDR_W   = 5,
   parameter int SRST_BIT = 31
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic [NUM_CNT-1:0] event_i,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_rvalid,
   output logic               soft_rst_o
);
   localparam int REG_W   = 2 * DATA_W;
   localparam int IDX_W   = ADDR_W - 1;
   localparam int NUM_MAP = NUM_CFG + NUM_CNT;

   if (NUM_CFG < 1) begin : g_bad_cfg
      $error("split64_bridge: NUM_CFG must be at least 1");
   end
   if (NUM_CNT < 1) begin : g_bad_cnt
      $error("split64_bridge: NUM_CNT must be at least 1");
   end
   if (NUM_MAP >= (1 << IDX_W)) begin : g_bad_map
      $error("split64_bridge: register map must leave unmapped indices");
   end
   if (SRST_BIT >= DATA_W) begin : g_bad_srst
      $error("split64_bridge: SRST_BIT outside the data word");
   end

   logic [IDX_W-1:0]              idx;
   half_e                         half;
   logic                          mapped, wr_en, rd_en, srst_cmd;
   logic [NUM_CFG-1:0][REG_W-1:0] cfg_q;
   logic [REG_W-1:0]              cnt_q [NUM_CNT];
   logic [REG_W-1:0]              regs  [NUM_MAP];
   logic [REG_W-1:0]              live;

   assign idx    = bus_addr[ADDR_W-1:1];
   assign half   = half_e'(bus_addr[0]);
   assign mapped = idx < IDX_W'(NUM_MAP);
   assign wr_en  = bus_valid && bus_write && (idx < IDX_W'(NUM_CFG));
   assign rd_en  = bus_valid && !bus_write;

   split64_cfg_bank #(
      .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .IDX_W(IDX_W), .SRST_BIT(SRST_BIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wr_half(half),
      .wdata(bus_wdata), .cfg_q(cfg_q), .srst_cmd(srst_cmd)
   );

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      split64_event_ctr #(.REG_W(REG_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .clr(srst_cmd), .ev(event_i[g]),
         .count(cnt_q[g])
      );
      assign regs[NUM_CFG + g] = cnt_q[g];
   end

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_map
      assign regs[g] = cfg_q[g];
   end

   always_comb begin
      live = '0;
      for (int i = 0; i < NUM_MAP; i++) begin
         if (idx == IDX_W'(i)) live = regs[i];
      end
   end

   split64_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mapped(mapped), .idx(idx),
      .half(half), .live(live), .rdata(bus_rdata), .rvalid(bus_rvalid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_rst_o <= 1'b0;
      else        soft_rst_o <= srst_cmd;
   end
endmodule

// File: rtl/split64_chk.sv
module split64_chk #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int NUM_MAP  = 5,
   parameter int SRST_BIT = 31,
   localparam int REG_W   = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_rvalid,
   input logic              soft_rst_o,
   input logic              srst_cmd,
   input logic              ev0,
   input logic [REG_W-1:0]  cnt0
);
   logic rd_req, unmapped_rd;
   assign rd_req      = bus_valid && !bus_write;
   assign unmapped_rd = rd_req && (bus_addr[ADDR_W-1:1] >= (ADDR_W-1)'(NUM_MAP));

   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> bus_rvalid); // R9
   AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !bus_rvalid); // R9
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped_rd |=> (bus_rdata == '0)); // R8
   AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o); // R7
   AST_SRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> $past(bus_valid && bus_write && (bus_addr == ADDR_W'(1))
                           && bus_wdata[SRST_BIT])); // R7
   AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      srst_cmd |=> (cnt0 == '0)); // R7
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !srst_cmd |=> (cnt0 == $past(cnt0) + REG_W'($past(ev0)))); // R6
endmodule

bind split64_bridge split64_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_MAP(NUM_CFG + NUM_CNT), .SRST_BIT(SRST_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .bus_rvalid(bus_rvalid), .soft_rst_o(soft_rst_o), .srst_cmd(srst_cmd),
   .ev0(event_i[0]), .cnt0(cnt_q[0])
);

// File: tb/test_split64_bridge.sv
module test_split64_bridge;
   localparam int DW = 32, NCFG = 2, NCNT = 3, AW = 5;
   localparam int NMAP = NCFG + NCNT;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0, bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [NCNT-1:0] event_i = '0;
   logic [DW-1:0] bus_rdata;
   logic          bus_rvalid, soft_rst_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [63:0] mcfg [NCFG];
   logic [63:0] mcnt [NCNT];
   logic [31:0] mstage, mshadow;
   bit          mpend;
   int          mpidx;
   bit          mphalf;

   always #2 clk = ~clk;

   split64_bridge #(.DATA_W(DW), .NUM_CFG(NCFG), .NUM_CNT(NCNT), .ADDR_W(AW)) i_split64_bridge (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .event_i(event_i),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .soft_rst_o(soft_rst_o)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] live_of(int idx);
      return (idx < NCFG) ? mcfg[idx] : mcnt[idx - NCFG];
   endfunction

   // one bus cycle: drive at negedge, model the edge, check at next negedge
   task automatic step(string tag, bit v, bit w, int a, logic [31:0] d, logic [NCNT-1:0] ev);
      int idx = a >> 1;
      bit hf = a[0];
      bit rd = v && !w;
      bit srst = 1'b0;
      logic [31:0] exp_rd = '0;
      logic [63:0] lv;
      bus_valid = v; bus_write = w; bus_addr = AW'(a); bus_wdata = d; event_i = ev;
      if (rd && idx < NMAP) begin
         lv = live_of(idx);
         if (mpend && mpidx == idx && mphalf == hf) begin
            exp_rd = mshadow; mpend = 1'b0;
         end else begin
            exp_rd  = hf ? lv[31:0] : lv[63:32];
            mshadow = hf ? lv[63:32] : lv[31:0];
            mpend = 1'b1; mpidx = idx; mphalf = !hf;
         end
      end
      if (v && w && idx < NCFG) begin
         if (!hf) mstage = d;
         else begin
            mcfg[idx] = {mstage, (idx == 0) ? (d & 32'h7fff_ffff) : d};
            srst = (idx == 0) && d[31];
            mstage = '0;
         end
      end
      for (int k = 0; k < NCNT; k++) mcnt[k] = srst ? 64'd0 : mcnt[k] + 64'(ev[k]);
      @(posedge clk);
      @(negedge clk);
      chk({tag, " rvalid (R9)"}, 64'(bus_rvalid), 64'(rd));
      if (rd) chk({tag, " rdata"}, 64'(bus_rdata), 64'(exp_rd));
      chk({tag, " soft_rst (R7)"}, 64'(soft_rst_o), 64'(srst));
   endtask

   task automatic rd(string tag, int a, logic [NCNT-1:0] ev = '0);
      step(tag, 1'b1, 1'b0, a, '0, ev);
   endtask
   task automatic wr(string tag, int a, logic [31:0] d, logic [NCNT-1:0] ev = '0);
      step(tag, 1'b1, 1'b1, a, d, ev);
   endtask

   initial begin : watchdog
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd1234));
      for (int i = 0; i < NCFG; i++) mcfg[i] = '0;
      for (int i = 0; i < NCNT; i++) mcnt[i] = '0;
      mstage = '0; mshadow = '0; mpend = 1'b0; mpidx = 0; mphalf = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 rvalid in reset", 64'(bus_rvalid), 64'd0);
      chk("R1 soft_rst in reset", 64'(soft_rst_o), 64'd0);
      rst_n = 1'b1;
      step("R1 idle", 1'b0, 1'b0, 0, '0, '0);
      rd("R1 cfg0 upper", 0);
      rd("R1 cfg0 lower", 1);
      rd("R1 cnt0 lower", 5);
      rd("R1 cnt2 upper", 8);
      // staging
      wr("R2 stage cfg1", 2, 32'hAAAA_5555);
      rd("R2 cfg1 upper unchanged", 2);
      rd("R2 cfg1 lower unchanged", 3);
      wr("R3 commit cfg1", 3, 32'h1234_5678);
      rd("R3 cfg1 upper", 2);
      rd("R3 cfg1 lower", 3);
      wr("R3 lone commit", 3, 32'h0000_0007);
      rd("R3 lone upper zero", 2);
      rd("R3 lone lower", 3);
      // coherent split read while counter runs
      for (int i = 0; i < 5; i++) step("R6 run", 1'b0, 1'b0, 0, '0, 3'b001);
      rd("R4 cnt0 upper first", 4, 3'b001);
      for (int i = 0; i < 4; i++) step("R6 run", 1'b0, 1'b0, 0, '0, 3'b001);
      rd("R4 cnt0 lower frozen", 5, 3'b001);
      rd("R6 cnt0 lower live", 5, 3'b001);
      rd("R4 cnt0 upper frozen", 4, 3'b011);
      rd("R4 cnt1 lower first", 7, 3'b010);
      rd("R4 cnt1 upper", 6, 3'b010);
      // refresh rules
      rd("R5 cfg1 lower first", 3);
      rd("R5 cfg0 upper refresh", 0);
      rd("R5 cfg0 lower from shadow", 1);
      rd("R5 cfg1 upper first", 2);
      rd("R5 cfg1 upper repeat", 2);
      rd("R5 cfg1 lower", 3);
      // unmapped and read-only
      rd("R8 cnt2 upper first", 8, 3'b100);
      rd("R8 unmapped read", 30, 3'b100);
      rd("R8 cnt2 lower shadow kept", 9, 3'b100);
      wr("R8 unmapped write hi", 12, 32'hFFFF_FFFF);
      wr("R8 unmapped write lo", 13, 32'hFFFF_FFFF);
      rd("R8 unmapped readback", 13);
      wr("R8 counter write hi", 4, 32'hDEAD_BEEF);
      wr("R8 counter write lo", 5, 32'hDEAD_BEEF);
      rd("R8 cnt0 upper", 4);
      rd("R8 cnt0 lower", 5);
      // soft reset command
      wr("R7 stage cfg0", 0, 32'h0000_00C3);
      wr("R7 commit srst", 1, 32'h8000_0011, 3'b111);
      rd("R7 cfg0 lower bit31 clear", 1, 3'b000);
      rd("R7 cfg0 upper", 0);
      rd("R7 cnt0 cleared", 5);
      rd("R7 cnt1 cleared", 7);
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         int a;
         bit v, w;
         logic [31:0] d;
         v = ($urandom % 8) != 0;
         w = ($urandom % 3) == 0;
         a = (($urandom % 4) == 0) ? int'($urandom % 32) : int'($urandom % (2 * NMAP));
         d = $urandom;
         if (($urandom % 4) != 0) d[31] = 1'b0;
         step((w ? "R3 random write" : (a >= 2 * NMAP ? "R8 random read" : "R4 random read")),
              v, w, a, d, NCNT'($urandom));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule